// File: doc/BRIEF.md
# Quadrant Memory Bank Controller

This block sits between a physical address source and external memory devices. For each read or write request it looks up one of four bank settings, chosen by the top two bits of a 20-bit physical address. Each setting covers one 256 KB quadrant. The block then runs a bus cycle of the configured length. During that cycle it drives active-low chip-select, output-enable and write-enable strobes, together with the two final upper address lines.

Each bank setting holds five things: a wait-state count, inversion of the two upper address lines, a write-inhibit bit, a choice between two enable-line pairs, and a choice of chip-select line. The upper lines are inverted only after the bank has been chosen. As a result, a single quadrant can page through a device larger than 256 KB. A separate mode register can hold chip-select 1 active at all times.

Requests use a valid/ready handshake. `req_ready` is high only when no cycle is running, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a cycle runs, `req_ready` stays low. A requester must hold its request, and a valid asserted during that time is ignored. Configuration writes are plain, write-only strobes with no handshake.

Top module: `qbank_ctrl`

## Requirements
- R1: Physical address bits 19:18 of an accepted request select which of the four bank settings (configuration addresses 0 to 3) governs the cycle.
- R2: A cycle lasts 2 clocks for a read or 3 clocks for a write, plus the wait-state count in bank bits 7:6. `done` is high only in the final clock of the cycle, and `cyc_len` shows the cycle length while the cycle runs.
- R3: `addr_hi` is {A19, A18} of the request, XORed with {bank bit 5, bank bit 4}. The uninverted bits choose the bank.
- R4: Bank bit 3 keeps both `we_n` lines high for a write in that quadrant. The cycle still runs its full length.
- R5: Bank bit 2 chooses the enable pair. A read drives `oe_n[pair]` low and a write drives `we_n[pair]` low for the whole cycle. The other lines stay high.
- R6: Bank bits 1:0 equal to 0, 1 or 2 drive `cs_n` of that index low for the whole cycle. The value 3 drives no chip select.
- R7: After reset, every bank setting and the mode register are zero, all strobes are high and `req_ready` is high. An access right after reset is therefore a 2-clock read on `cs_n[0]` and `oe_n[0]`.
- R8: Bit 0 of the mode register (configuration address 4) holds `cs_n[1]` low at all times, including when idle.
- R9: `req_ready` is low for every clock of a cycle. A `req_valid` seen while busy starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0 to 3: bank setting, 4: mode register |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Physical address |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables, one per pair |
| we_n | output | 2 | Active-low write enables, one per pair |
| addr_hi | output | 2 | Final {A19, A18} |
| cyc_len | output | 3 | Length of the running cycle in clocks |
| done | output | 1 | High in the final clock of a cycle |

## Verification
Random bank settings are paired with random addresses and directions. This covers every quadrant, every wait-state count and every inversion, pair and chip-select value. It separates a wrong bank choice from a wrong field decode.

Directed cases cover the following:
- The reset-state read.
- The example quadrant at 80000h with A18 inversion, which shows that inversion comes after bank selection.
- An inhibited write, which shows the strobe is dropped while the length is kept.
- Chip-select code 3.
- The forced chip-select mode, checked while idle.
- A request held during a busy cycle, which must be ignored.

// File: rtl/qbank_pkg.sv
package qbank_pkg;
  // Bank setting, packed in configuration-byte bit order (7..0).
  typedef struct packed {
    logic [1:0] ws;      // 7:6 wait states
    logic       inv19;   // 5
    logic       inv18;   // 4
    logic       no_we;   // 3
    logic       pair;    // 2
    logic [1:0] csel;    // 1:0
  } bank_cfg_t;

  localparam int unsigned CFG_W = $bits(bank_cfg_t);
endpackage

// File: rtl/qbank_regs.sv
module qbank_regs
  import qbank_pkg::*;
#(
  parameter int unsigned NB     = 4,
  parameter int unsigned CADR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CADR_W-1:0]      cfg_addr,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output bank_cfg_t [NB-1:0]     banks,
  output logic                   force_cs
);
  localparam logic [CADR_W-1:0] MODE_ADR = CADR_W'(NB);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   banks[b] <= '0;
      else if (cfg_we && cfg_addr == CADR_W'(b))    banks[b] <= bank_cfg_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              force_cs <= 1'b0;
    else if (cfg_we && cfg_addr == MODE_ADR) force_cs <= cfg_wdata[0];
  end

  // R7: settings are zero on the first clock after reset
  assert_reset_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (banks == '0 && !force_cs));
endmodule

// File: rtl/qbank_seq.sv
module qbank_seq #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] cnt;

  assign done = busy && (cnt == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + LEN_W'(1);
    end
  end

  // R9: a cycle starts only from idle
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R2: the final clock ends the cycle, earlier clocks do not
  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/qbank_strobe.sv
module qbank_strobe
  import qbank_pkg::*;
#(
  parameter int unsigned N_CS   = 3,
  parameter int unsigned N_PAIR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr,
  input  bank_cfg_t         cfg,
  input  logic              force_cs,
  output logic [N_CS-1:0]   cs_n,
  output logic [N_PAIR-1:0] oe_n,
  output logic [N_PAIR-1:0] we_n
);
  for (genvar c = 0; c < N_CS; c++) begin : g_cs
    if (c == 1) begin : g_forced
      assign cs_n[c] = !(force_cs || (busy && cfg.csel == 2'(c)));
    end else begin : g_plain
      assign cs_n[c] = !(busy && cfg.csel == 2'(c));
    end
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign oe_n[p] = !(busy && !wr && cfg.pair == 1'(p));
    assign we_n[p] = !(busy && wr && !cfg.no_we && cfg.pair == 1'(p));
  end

  // R5: enables are released when idle and never both directions at once
  assert_idle_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&oe_n && &we_n));
  assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~{oe_n, we_n}) <= 1);
  // R8: forced select holds regardless of activity
  assert_force_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_cs |-> !cs_n[1]);
endmodule

// File: rtl/qbank_ctrl.sv
module qbank_ctrl
  import qbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned N_CS    = 3,
  parameter int unsigned N_PAIR  = 2,
  parameter int unsigned RD_BASE = 2,
  parameter int unsigned WR_BASE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [N_CS-1:0]   cs_n,
  output logic [N_PAIR-1:0] oe_n,
  output logic [N_PAIR-1:0] we_n,
  output logic [1:0]        addr_hi,
  output logic [2:0]        cyc_len,
  output logic              done
);
  localparam int unsigned NB     = 4;
  localparam int unsigned MAX_WS = 3;
  localparam int unsigned LEN_W  = $clog2(WR_BASE + MAX_WS + 1);

  bank_cfg_t [NB-1:0] banks;
  bank_cfg_t          sel_cfg, q_cfg;
  logic               force_cs, busy, accept, q_wr;
  logic [1:0]         q_ahi, quad;
  logic [LEN_W-1:0]   q_len;

  qbank_regs #(.NB(NB), .CADR_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .banks(banks), .force_cs(force_cs));

  assign quad      = req_addr[ADDR_W-1 -: 2];
  assign sel_cfg   = banks[quad];
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cfg <= '0;
      q_wr  <= 1'b0;
      q_ahi <= '0;
      q_len <= LEN_W'(RD_BASE);
    end else if (accept) begin
      q_cfg <= sel_cfg;
      q_wr  <= req_write;
      q_ahi <= quad ^ {sel_cfg.inv19, sel_cfg.inv18};
      q_len <= (req_write ? LEN_W'(WR_BASE) : LEN_W'(RD_BASE)) + LEN_W'(sel_cfg.ws);
    end
  end

  qbank_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .len(q_len),
    .busy(busy), .done(done));

  qbank_strobe #(.N_CS(N_CS), .N_PAIR(N_PAIR)) u_strobe (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr(q_wr), .cfg(q_cfg),
    .force_cs(force_cs), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n));

  assign addr_hi = q_ahi;
  assign cyc_len = 3'(q_len);

  // Independent cycle counter for the length check
  logic [LEN_W-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_cnt <= '0;
    else if (accept) chk_cnt <= LEN_W'(1);
    else if (busy)   chk_cnt <= chk_cnt + LEN_W'(1);
  end

  // R2: done arrives exactly after cyc_len busy clocks
  assert_len_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_cnt == q_len));
  // R9: no handshake while a cycle runs
  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

// File: tb/sim_qbank_ctrl.sv
module sim_qbank_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [19:0] req_addr = 0;
  logic req_ready, done; logic [2:0] cs_n, cyc_len; logic [1:0] oe_n, we_n, addr_hi;

  int checks = 0, errors = 0;
  logic [7:0] shadow [4];
  logic       mode_f = 0;

  always #4 clk = ~clk;

  qbank_ctrl u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .req_valid, .req_ready,
    .req_write, .req_addr, .cs_n, .oe_n, .we_n, .addr_hi, .cyc_len, .done);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cs(logic [7:0] b, logic active);
    logic [2:0] r = 3'b111;
    if (active && b[1:0] != 2'd3) r[b[1:0]] = 1'b0;
    if (mode_f) r[1] = 1'b0;
    return r;
  endfunction

  task automatic cfg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a < 4) shadow[a] = d; else mode_f = d[0];
  endtask

  // Run one access and compare every clock against the model
  task automatic access(logic [19:0] a, logic wr, string tag);
    logic [7:0] b = shadow[a[19:18]];
    int len = (wr ? 3 : 2) + int'(b[7:6]);
    logic [1:0] eo = 2'b11, ew = 2'b11;
    int n = 0;
    if (!wr) eo[b[2]] = 1'b0; else if (!b[3]) ew[b[2]] = 1'b0;
    @(negedge clk); req_valid = 1; req_addr = a; req_write = wr;
    @(negedge clk); req_valid = 0;
    chk({tag, " R9 ready low"}, int'(req_ready), 0);
    chk({tag, " R2 cyc_len"}, int'(cyc_len), len);
    chk({tag, " R3 addr_hi"}, int'(addr_hi), int'(a[19:18] ^ b[5:4]));
    while (1) begin
      n++;
      if (n > 20) begin chk({tag, " R2 watchdog"}, n, len); break; end
      if (cs_n != exp_cs(b, 1) || oe_n != eo || we_n != ew) begin
        chk({tag, " R1 R4 R5 R6 strobes"}, int'({cs_n, oe_n, we_n}), int'({exp_cs(b, 1), eo, ew}));
      end
      if (done) break;
      @(negedge clk);
    end
    chk({tag, " R2 length"}, n, len);
    @(negedge clk);
    chk({tag, " R7 idle strobes"}, int'({cs_n, oe_n, we_n}), int'({exp_cs(b, 0), 4'hf}));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 reset strobes", int'({cs_n, oe_n, we_n}), 7'h7f);
    chk("R7 reset ready", int'(req_ready), 1);
    rst_n = 1;
    access(20'h12345, 0, "R7 reset read");
    // Example quadrant: bit 4 set on quadrant 2, selection unaffected
    cfg(3'd2, 8'b0101_0110);
    access(20'h80000, 0, "R3 invA18 q2");
    access(20'hBFFFF, 1, "R3 invA18 q2 wr");
    access(20'h40000, 1, "R1 q1 untouched");
    // Write inhibit, full length kept
    cfg(3'd3, 8'b1110_1101);
    access(20'hC0010, 1, "R4 inhibit");
    // Chip select code 3
    cfg(3'd1, 8'b0000_0011);
    access(20'h40004, 0, "R6 no cs");
    // Forced chip select while idle
    cfg(3'd4, 8'h01);
    @(negedge clk);
    chk("R8 forced idle", int'(cs_n), 3'b101);
    access(20'h00100, 1, "R8 forced access");
    cfg(3'd4, 8'h00);
    @(negedge clk);
    chk("R8 released", int'(cs_n), 3'b111);
    // Request held while busy must be ignored
    @(negedge clk); req_valid = 1; req_addr = 20'hC0000; req_write = 1;
    @(negedge clk); req_addr = 20'h00000; req_write = 0;
    chk("R9 busy ready low", int'(req_ready), 0);
    @(negedge clk); req_valid = 0;
    repeat (8) @(negedge clk);
    chk("R9 one cycle only", int'({req_ready, cs_n}), int'({1'b1, 3'b111}));
    // Random mix
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 0) cfg(3'($urandom_range(0, 3)), 8'($urandom));
      access(20'($urandom), 1'($urandom), "R1 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule